// File: doc/BRIEF.md
# Block-Linked Free Buffer Manager

This block owns the allocation state of a shared frame memory that is divided into fixed 128-byte blocks. Each block is named by a handle. After reset the manager spends one cycle per block chaining every handle into a single linked free list. It then hands the head handle to one requesting receive port per cycle and links every released handle back onto the tail of the list.

Allocation is gated per port. Each port has a ceiling on the blocks it may hold. The ceiling covers a standard maximum-size frame of 1522 bytes, or up to 4096 bytes when that port's jumbo enable is set. Each port also has a guaranteed reservation that no other port may consume. A port that hits its ceiling while still asking for blocks raises a flow-control signal toward its source. That signal drops only after the port's usage has fallen a hysteresis margin below the ceiling. Frame data movement is not part of this block.

Top module: `blk_buf_mgr`

## Requirements
- R1: After reset `init_busy_o` is 1 and `free_count_o` is 0. `init_busy_o` falls after exactly NUM_BLOCKS rising edges, and `free_count_o` then reads NUM_BLOCKS. Requests and releases presented while `init_busy_o` is 1 are ignored.
- R2: Handles are the integers 0 to NUM_BLOCKS-1. After initialisation the list holds them in ascending order, and each grant carries the handle at the head of the list.
- R3: A released handle is appended behind every handle already free, so it is granted again only after those handles.
- R4: At most one port is granted per cycle. `gnt_o` is one-hot, with bit p meaning port p. Eligible ports are served round-robin, starting after the most recently granted port.
- R5: A request sampled at a rising edge produces `gnt_o` and `gnt_handle_o` at that edge. At the same edge the granted port's usage rises by 1 and `free_count_o` falls by 1. A release (`rel_valid_i` with a binary port number in `rel_port_i`) lowers that port's usage and raises the free count at the edge where it is sampled. Usage of port p is read from `usage_o[p*CW +: CW]`, where CW is $clog2(NUM_BLOCKS+1). `gnt_handle_o` is 0 in cycles without a grant.
- R6: A port's block ceiling is FRAMES_PER_PORT*ceil(1522/128), which is 12 by default. When that port's `jumbo_en_i` bit is 1 the ceiling is FRAMES_PER_PORT*ceil(4096/128), which is 32. A port whose usage is at its ceiling is not granted.
- R7: A port that requests while its usage is at or above its ceiling has its `fc_o` bit set at that edge. The bit clears at the first edge where usage plus FC_HYST is below the ceiling.
- R8: A port is granted only if the free count minus one is at least the sum of the unused reservations of all other ports. The unused reservation of a port is RESERVE_BLOCKS minus its usage, or 0 when that difference is negative.
- R9: No grant is issued while the free list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | NUM_PORTS | Per-port block request |
| jumbo_en_i | input | NUM_PORTS | Per-port jumbo ceiling select |
| rel_valid_i | input | 1 | Release strobe |
| rel_port_i | input | PW | Port returning the block (binary) |
| rel_handle_i | input | HW | Handle being returned |
| gnt_o | output | NUM_PORTS | One-hot grant |
| gnt_handle_o | output | HW | Granted handle |
| init_busy_o | output | 1 | Free list being built |
| free_count_o | output | CW | Handles in the free list |
| usage_o | output | NUM_PORTS*CW | Per-port held blocks, packed |
| fc_o | output | NUM_PORTS | Per-port flow-control assert |

## Verification
Grant, handle, usage and free count are all due at the first rising edge after a request or release is sampled. The flow-control bit responds to usage as it stood before that edge, so it settles one edge after the usage change that moves it. The bench drives inputs and samples outputs on falling edges. It advances a behavioural model, built from handle queues and counters, once per edge, so every output is compared exactly in the cycle it is due. Directed phases then read the ports at points chosen for the ceiling, hysteresis, reservation, empty-list and round-robin cases.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/bbm_free_list.sv
module bbm_free_list #(
   parameter int N  = 64,
   parameter int HW = 6,
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic          push,
   input  logic [HW-1:0] push_handle,
   output logic          busy,
   output logic [HW-1:0] head,
   output logic [CW-1:0] count
);
   logic [HW-1:0] link_mem [N];
   logic [HW-1:0] build_idx;
   logic [HW-1:0] tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b1;
         build_idx <= '0;
         head      <= '0;
         tail      <= '0;
         count     <= '0;
      end else if (busy) begin
         build_idx <= build_idx + 1'b1;
         if (build_idx == HW'(N - 1)) begin
            busy  <= 1'b0;
            head  <= '0;
            tail  <= HW'(N - 1);
            count <= CW'(N);
         end
      end else begin
         count <= count + CW'(push) - CW'(pop);
         if (push && (count == '0 || (count == CW'(1) && pop)))
            head <= push_handle;
         else if (pop)
            head <= link_mem[head];
         if (push)
            tail <= push_handle;
      end
   end

   always_ff @(posedge clk) begin
      if (busy)
         link_mem[build_idx] <= build_idx + 1'b1;
      else if (push)
         link_mem[tail] <= push_handle;
   end

   p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0 && !busy)) else $error("pop from empty list");
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(N)) else $error("free count above capacity");
   p_empty_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> count == '0) else $error("count nonzero during build");
endmodule

// File: rtl/bbm_port_ctr.sv
module bbm_port_ctr #(
   parameter int CW      = 7,
   parameter int LIM_STD = 12,
   parameter int LIM_JMB = 32,
   parameter int HYST    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          jumbo,
   input  logic          req_seen,
   output logic [CW-1:0] usage,
   output logic          at_limit,
   output logic          fc
);
   logic [CW-1:0] lim;

   assign lim      = jumbo ? CW'(LIM_JMB) : CW'(LIM_STD);
   assign at_limit = usage >= lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usage <= '0;
         fc    <= 1'b0;
      end else begin
         usage <= usage + CW'(inc) - CW'(dec);
         if (req_seen && at_limit)
            fc <= 1'b1;
         else if (int'(usage) + HYST < int'(lim))
            fc <= 1'b0;
      end
   end

   p_inc_below_lim_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> usage < lim) else $error("grant beyond ceiling");
   p_fc_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fc) |-> $past(req_seen && at_limit)) else $error("fc rose without cause");
   p_fc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fc && int'(usage) + HYST >= int'(lim)) |=> fc) else $error("fc dropped early");
endmodule

// File: rtl/bbm_rr_arb.sv
module bbm_rr_arb #(
   parameter int P  = 4,
   parameter int PW = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [P-1:0] elig,
   output logic [P-1:0] grant
);
   logic [PW-1:0] rr_ptr;
   logic [PW-1:0] sel;
   logic [PW-1:0] idx;
   logic          found;

   always_comb begin
      grant = '0;
      found = 1'b0;
      sel   = '0;
      idx   = '0;
      for (int k = 0; k < P; k++) begin
         idx = PW'((int'(rr_ptr) + k) % P);
         if (!found && elig[idx]) begin
            grant[idx] = 1'b1;
            found      = 1'b1;
            sel        = idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_ptr <= '0;
      else if (found)
         rr_ptr <= (sel == PW'(P - 1)) ? '0 : sel + 1'b1;
   end

   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)) else $error("multiple grants");
   p_grant_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~elig) == '0) else $error("grant to ineligible port");
endmodule

// File: rtl/blk_buf_mgr.sv
module blk_buf_mgr #(
   parameter int NUM_PORTS         = 4,
   parameter int NUM_BLOCKS        = 64,
   parameter int BLOCK_BYTES       = 128,
   parameter int STD_FRAME_BYTES   = 1522,
   parameter int JUMBO_FRAME_BYTES = 4096,
   parameter int FRAMES_PER_PORT   = 1,
   parameter int RESERVE_BLOCKS    = 4,
   parameter int FC_HYST           = 2,
   localparam int HW      = $clog2(NUM_BLOCKS),
   localparam int CW      = $clog2(NUM_BLOCKS + 1),
   localparam int PW      = $clog2(NUM_PORTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_PORTS-1:0]    req_i,
   input  logic [NUM_PORTS-1:0]    jumbo_en_i,
   input  logic                    rel_valid_i,
   input  logic [PW-1:0]           rel_port_i,
   input  logic [HW-1:0]           rel_handle_i,
   output logic [NUM_PORTS-1:0]    gnt_o,
   output logic [HW-1:0]           gnt_handle_o,
   output logic                    init_busy_o,
   output logic [CW-1:0]           free_count_o,
   output logic [NUM_PORTS*CW-1:0] usage_o,
   output logic [NUM_PORTS-1:0]    fc_o
);
   import bbm_pkg::*;

   localparam int LIM_STD = FRAMES_PER_PORT * ceil_div(STD_FRAME_BYTES, BLOCK_BYTES);
   localparam int LIM_JMB = FRAMES_PER_PORT * ceil_div(JUMBO_FRAME_BYTES, BLOCK_BYTES);

   initial begin
      a_cfg_ports: assert (NUM_PORTS >= 2) else $error("need two or more ports");
      a_cfg_blocks: assert (NUM_BLOCKS >= 2 && LIM_JMB <= NUM_BLOCKS)
         else $error("jumbo ceiling exceeds memory");
      a_cfg_rsv: assert (RESERVE_BLOCKS * NUM_PORTS <= NUM_BLOCKS && RESERVE_BLOCKS <= LIM_STD)
         else $error("reservations exceed memory");
      a_cfg_hyst: assert (FC_HYST < LIM_STD) else $error("hysteresis too large");
   end

   logic                 busy;
   logic [HW-1:0]        head;
   logic [CW-1:0]        count;
   logic [NUM_PORTS-1:0] elig;
   logic [NUM_PORTS-1:0] grant;
   logic [NUM_PORTS-1:0] at_lim;
   logic [CW-1:0]        usage [NUM_PORTS];
   logic                 alloc;
   logic                 rel_ok;
   int                   unused_rsv [NUM_PORTS];
   int                   total_unused;
   int                   used_sum;

   assign alloc  = |grant;
   assign rel_ok = rel_valid_i && !busy;

   bbm_free_list #(.N(NUM_BLOCKS), .HW(HW), .CW(CW)) u_list (
      .clk(clk), .rst_n(rst_n), .pop(alloc), .push(rel_ok),
      .push_handle(rel_handle_i), .busy(busy), .head(head), .count(count)
   );

   always_comb begin
      total_unused = 0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         unused_rsv[p] = (int'(usage[p]) < RESERVE_BLOCKS) ?
                         RESERVE_BLOCKS - int'(usage[p]) : 0;
         total_unused  = total_unused + unused_rsv[p];
      end
      for (int p = 0; p < NUM_PORTS; p++)
         elig[p] = req_i[p] && !busy && !at_lim[p] && (count != '0) &&
                   (int'(count) - 1 >= total_unused - unused_rsv[p]);
   end

   bbm_rr_arb #(.P(NUM_PORTS), .PW(PW)) u_arb (
      .clk(clk), .rst_n(rst_n), .elig(elig), .grant(grant)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      bbm_port_ctr #(.CW(CW), .LIM_STD(LIM_STD), .LIM_JMB(LIM_JMB), .HYST(FC_HYST)) u_ctr (
         .clk(clk), .rst_n(rst_n), .inc(grant[p]),
         .dec(rel_ok && rel_port_i == PW'(p)), .jumbo(jumbo_en_i[p]),
         .req_seen(req_i[p] && !busy), .usage(usage[p]),
         .at_limit(at_lim[p]), .fc(fc_o[p])
      );
      assign usage_o[p*CW +: CW] = usage[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_o        <= '0;
         gnt_handle_o <= '0;
      end else begin
         gnt_o        <= grant;
         gnt_handle_o <= alloc ? head : '0;
      end
   end

   assign init_busy_o  = busy;
   assign free_count_o = count;

   always_comb begin
      used_sum = 0;
      for (int p = 0; p < NUM_PORTS; p++)
         used_sum = used_sum + int'(usage[p]);
   end

   p_conserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> used_sum + int'(count) == NUM_BLOCKS) else $error("blocks lost");
   p_rsv_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> int'(count) >= total_unused) else $error("reservation consumed");
   p_no_grant_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> gnt_o == '0) else $error("grant during build");
endmodule

// File: tb/blk_buf_mgr_tb_top.sv
`timescale 1ns/1ps
module blk_buf_mgr_tb_top;
   localparam int P     = 4;
   localparam int N     = 64;
   localparam int HW    = 6;
   localparam int CW    = 7;
   localparam int PW    = 2;
   localparam int LIM_S = 12;
   localparam int LIM_J = 32;
   localparam int RSV   = 4;
   localparam int HYST  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [P-1:0]    req = '0;
   logic [P-1:0]    jmb = '0;
   logic            rv = 1'b0;
   logic [PW-1:0]   rp = '0;
   logic [HW-1:0]   rh = '0;
   logic [P-1:0]    gnt;
   logic [HW-1:0]   gh;
   logic            busy;
   logic [CW-1:0]   fcnt;
   logic [P*CW-1:0] use_bus;
   logic [P-1:0]    fc;

   always #2.5 clk = ~clk;

   blk_buf_mgr dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .jumbo_en_i(jmb),
      .rel_valid_i(rv), .rel_port_i(rp), .rel_handle_i(rh),
      .gnt_o(gnt), .gnt_handle_o(gh), .init_busy_o(busy),
      .free_count_o(fcnt), .usage_o(use_bus), .fc_o(fc)
   );

   int n_checks = 0;
   int n_err    = 0;
   int m_init_left = N;
   int m_free[$];
   int m_use[P];
   bit m_fc[P];
   int m_rr = 0;
   int m_gnt = 0;
   int m_handle = 0;
   int owned[P][$];
   int log_handles[$];
   int log_ports[$];
   int p3_handles[$];

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int use_of(input int p);
      return int'(use_bus[p*CW +: CW]);
   endfunction

   task automatic model_step(input logic [P-1:0] q, input logic [P-1:0] j,
                             input bit v, input int vp, input int vh);
      int lim[P];
      int un[P];
      int tot;
      int g;
      for (int p = 0; p < P; p++) lim[p] = j[p] ? LIM_J : LIM_S;
      if (m_init_left > 0) begin
         m_init_left--;
         if (m_init_left == 0)
            for (int i = 0; i < N; i++) m_free.push_back(i);
         m_gnt = 0;
         m_handle = 0;
      end else begin
         tot = 0;
         for (int p = 0; p < P; p++) begin
            un[p] = (m_use[p] < RSV) ? RSV - m_use[p] : 0;
            tot += un[p];
         end
         g = -1;
         for (int k = 0; k < P; k++) begin
            int p;
            p = (m_rr + k) % P;
            if (g < 0 && q[p] && m_use[p] < lim[p] && m_free.size() > 0 &&
                m_free.size() - 1 >= tot - un[p])
               g = p;
         end
         for (int p = 0; p < P; p++) begin
            if (q[p] && m_use[p] >= lim[p]) m_fc[p] = 1'b1;
            else if (m_use[p] + HYST < lim[p]) m_fc[p] = 1'b0;
         end
         m_gnt = 0;
         m_handle = 0;
         if (g >= 0) begin
            m_handle = m_free.pop_front();
            m_gnt = 1 << g;
            owned[g].push_back(m_handle);
            m_use[g]++;
            m_rr = (g + 1) % P;
         end
         if (v) begin
            m_free.push_back(vh);
            m_use[vp]--;
         end
      end
   endtask

   task automatic do_cyc(input logic [P-1:0] q, input bit v, input int vp, input int vh);
      req = q;
      rv  = v;
      rp  = PW'(vp);
      rh  = HW'(vh);
      model_step(q, jmb, v, vp, vh);
      @(posedge clk);
      @(negedge clk);
      chk("R1 busy", int'(busy), int'(m_init_left > 0));
      chk("R5 free count", int'(fcnt), m_free.size());
      chk("R4 grant", int'(gnt), m_gnt);
      chk("R2 handle", int'(gh), m_handle);
      for (int p = 0; p < P; p++) begin
         chk("R5 usage", use_of(p), m_use[p]);
         chk("R7 fc", int'(fc[p]), int'(m_fc[p]));
      end
      for (int p = 0; p < P; p++)
         if (gnt[p]) begin
            log_handles.push_back(int'(gh));
            log_ports.push_back(p);
            if (p == 3) p3_handles.push_back(int'(gh));
         end
   endtask

   task automatic rel_one(input int p, input logic [P-1:0] q);
      int h;
      if (owned[p].size() > 0) begin
         h = owned[p].pop_front();
         do_cyc(q, 1'b1, p, h);
      end else begin
         do_cyc(q, 1'b0, 0, 0);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
   endtask

   initial begin
      #(5.0 * 100000);
      n_err++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int p = 0; p < P; p++) begin m_use[p] = 0; m_fc[p] = 0; end
      repeat (3) @(negedge clk);
      chk("R1 reset busy", int'(busy), 1);
      chk("R1 reset count", int'(fcnt), 0);
      chk("R4 reset grant", int'(gnt), 0);
      rst_n = 1'b1;

      // R1: requests during build are ignored
      for (int i = 0; i < N; i++) do_cyc('1, 1'b0, 0, 0);
      chk("R1 built count", int'(fcnt), N);
      chk("R1 busy low", int'(busy), 0);

      // R2, R6, R7: port 0 standard ceiling
      log_handles.delete();
      for (int i = 0; i < 14; i++) do_cyc(4'b0001, 1'b0, 0, 0);
      for (int i = 0; i < 12; i++) chk("R2 ascending handle", log_handles[i], i);
      chk("R6 std ceiling", use_of(0), LIM_S);
      chk("R7 fc at ceiling", int'(fc[0]), 1);
      rel_one(0, '0);
      rel_one(0, '0);
      chk("R7 fc held in hysteresis", int'(fc[0]), 1);
      rel_one(0, '0);
      do_cyc('0, 1'b0, 0, 0);
      chk("R7 fc cleared", int'(fc[0]), 0);

      // R6: jumbo ceiling on port 1, then port 2 standard
      jmb = 4'b0010;
      for (int i = 0; i < 40; i++) do_cyc(4'b0010, 1'b0, 0, 0);
      chk("R6 jumbo ceiling", use_of(1), LIM_J);
      for (int i = 0; i < 40; i++) do_cyc(4'b0100, 1'b0, 0, 0);
      chk("R6 std ceiling p2", use_of(2), LIM_S);

      // R8: port 0 stops at port 3's reservation
      jmb = 4'b0011;
      for (int i = 0; i < 20; i++) do_cyc(4'b0001, 1'b0, 0, 0);
      chk("R8 reserve left", int'(fcnt), RSV);
      chk("R8 usage p0", use_of(0), 16);
      chk("R8 refused", int'(gnt), 0);

      // R3, R9: port 3 drains list; released handles come last
      for (int i = 0; i < 10; i++) do_cyc(4'b1000, 1'b0, 0, 0);
      chk("R3 count p3", p3_handles.size(), 4);
      if (p3_handles.size() == 4) begin
         chk("R3 tail order 0", p3_handles[0], 63);
         chk("R3 tail order 1", p3_handles[1], 0);
         chk("R3 tail order 2", p3_handles[2], 1);
         chk("R3 tail order 3", p3_handles[3], 2);
      end
      chk("R9 empty count", int'(fcnt), 0);
      chk("R9 no grant", int'(gnt), 0);

      // return everything
      for (int p = 0; p < P; p++)
         while (owned[p].size() > 0) rel_one(p, '0);
      chk("R5 all returned", int'(fcnt), N);

      // R4: round robin
      log_ports.delete();
      for (int i = 0; i < 8; i++) do_cyc('1, 1'b0, 0, 0);
      for (int i = 0; i < 8; i++) chk("R4 rotation", log_ports[i], i % P);

      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         int p;
         if (i % 200 == 0) jmb = P'($urandom);
         p = $urandom_range(P - 1);
         if ($urandom_range(1) == 1 && owned[p].size() > 0)
            rel_one(p, P'($urandom));
         else
            do_cyc(P'($urandom), 1'b0, 0, 0);
      end

      summary();
      $finish;
   end
endmodule